// File: doc/BRIEF.md
# Read-Bypassing Processor Write Buffer

This block sits between a processor's load/store port and a single-master I/O bus. Stores are posted into a six-entry queue, so the processor continues without stalling while there is room. When the queue is full, a new store is held off until an entry retires. Queued stores drain to the bus in the order they entered, and a new write cycle starts no sooner than three cycles after the previous one.

A load is given priority over the queued stores and goes to the bus first. When it goes out, every queued store that lies in the same eight-word (32-byte) block is recorded. If there was at least one such store, the first read's data is discarded. The recorded stores are allowed to retire, and then the read is issued a second time. The target therefore sees two reads for one load, and the processor receives the data from the second read.

Any bus cycle that the target ends with a conflict response is issued again, with no retry limit. Between attempts, other pending work may use the bus. A flush request is acknowledged only once the store queue is empty.

Top module: `rd_bypass_wbuf`

## Requirements
- R1: The queue holds six stores. With fewer than six stores queued, a store request is accepted in the cycle it is presented, and `cpu_wr_stall` stays low.
- R2: When a load is requested and no earlier read is waiting on a retry, the read is the next bus cycle started, ahead of every queued store. A bus cycle already in progress is allowed to complete first.
- R3: A load issues a read to its address. If, at that moment, a queued store falls in the same block, a second read is issued once all of those stores have retired. The load returns the data of the second read, and the target sees exactly two normally completed reads. With no such store, exactly one normally completed read occurs.
- R4: Two write cycles never start on the bus less than three clock cycles apart.
- R5: A bus cycle that ends with `bus_conflict` high alongside `bus_done` is reissued with the same kind, address and data, as often as needed and with no limit. While `bus_valid` is high and `bus_done` is low, the cycle's address, data and direction hold steady.
- R6: While a conflicted store waits for reissue, a pending load may start on the bus before that store is retried.
- R7: `flush_ack` is high only while `flush_req` is high and no store remains queued or in flight. Once the queue drains, it goes high.
- R8: Stores complete on the bus in exactly the order in which they were accepted.
- R9: With six stores queued, `cpu_wr_stall` is high and a presented store is held off. It is accepted once a queued store completes normally on the bus.
- R10: The block match compares address bits [31:5] and ignores bits [4:0]. Addresses 0x401C and 0x4000 match; addresses 0x6020 and 0x6000 do not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr_req | input | 1 | Store request, held until accepted |
| cpu_wr_addr | input | 32 | Store byte address |
| cpu_wr_data | input | 32 | Store data |
| cpu_wr_stall | output | 1 | Store queue full; store not accepted this cycle |
| cpu_rd_req | input | 1 | Load request, held until `cpu_rd_done` |
| cpu_rd_addr | input | 32 | Load byte address |
| cpu_rd_done | output | 1 | One-cycle pulse: load data valid |
| cpu_rd_data | output | 32 | Load data |
| flush_req | input | 1 | Request to wait for the store queue to drain |
| flush_ack | output | 1 | Store queue drained while flush requested |
| bus_valid | output | 1 | Bus cycle active, held until `bus_done` |
| bus_we | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_addr | output | 32 | Bus cycle address |
| bus_wdata | output | 32 | Bus write data |
| bus_done | input | 1 | Target ends the current cycle |
| bus_conflict | input | 1 | With `bus_done`: cycle refused, must be retried |
| bus_rdata | input | 32 | Read data, valid with `bus_done` |

## Verification
Loads are presented in three situations. First, behind stores that lie in other blocks, which shows that the read overtakes the queue and is served by a single read. Second, behind a store in the same block but a different word (0x401C against 0x4000), which shows that the low five address bits are ignored and forces the double read. Third, next to a store at a neighbouring block (0x6020 against 0x6000), which shows that there is no false match. A load that follows a same-address store must return the stored value, which proves the second read came after the store. A forced conflict on a store while a load waits tells reissue apart from loss and shows the load going in between. A long random mix of stores and loads over eight blocks, with conflict responses on a fifth of the cycles, compares load data, write order and the spacing between write starts against a model kept in the bench.

// File: rtl/wb_pkg.sv
package wb_pkg;
   typedef enum logic {
      WB_IDLE = 1'b0,
      WB_BUSY = 1'b1
   } wb_state_e;

   function automatic int wb_blk_lsb(input int words, input int dw);
      return $clog2(words * dw / 8);
   endfunction
endpackage

// File: rtl/wb_store_fifo.sv
module wb_store_fifo #(
   parameter int DEPTH   = 6,
   parameter int AW      = 32,
   parameter int DW      = 32,
   parameter int BLK_LSB = 5,
   localparam int IW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW     = $clog2(DEPTH + 1),
   localparam int BW     = AW - BLK_LSB
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_i,
   input  logic [AW-1:0]    push_addr_i,
   input  logic [DW-1:0]    push_data_i,
   input  logic             pop_i,
   output logic             full_o,
   output logic             empty_o,
   output logic [IW-1:0]    head_idx_o,
   output logic [AW-1:0]    head_addr_o,
   output logic [DW-1:0]    head_data_o,
   input  logic [BW-1:0]    look_blk_i,
   output logic [DEPTH-1:0] hit_o
);
   localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);
   localparam logic [CW-1:0] CMAX = CW'(DEPTH);

   if (DEPTH < 2) $error("wb_store_fifo: DEPTH must be at least 2");
   if (BLK_LSB >= AW) $error("wb_store_fifo: block offset wider than address");

   logic [AW-1:0]    addr_q [DEPTH];
   logic [DW-1:0]    data_q [DEPTH];
   logic [DEPTH-1:0] vld_q;
   logic [IW-1:0]    wr_ptr, rd_ptr;
   logic [CW-1:0]    cnt;

   function automatic logic [IW-1:0] step(input logic [IW-1:0] p);
      return (p == LAST) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk) begin
      if (push_i) begin
         addr_q[wr_ptr] <= push_addr_i;
         data_q[wr_ptr] <= push_data_i;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
         vld_q  <= '0;
      end else begin
         if (push_i) begin
            vld_q[wr_ptr] <= 1'b1;
            wr_ptr        <= step(wr_ptr);
         end
         if (pop_i) begin
            vld_q[rd_ptr] <= 1'b0;
            rd_ptr        <= step(rd_ptr);
         end
         case ({push_i, pop_i})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   assign full_o      = (cnt == CMAX);
   assign empty_o     = (cnt == '0);
   assign head_idx_o  = rd_ptr;
   assign head_addr_o = addr_q[rd_ptr];
   assign head_data_o = data_q[rd_ptr];

   for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
      assign hit_o[g] = vld_q[g] && (addr_q[g][AW-1:BLK_LSB] == look_blk_i);
   end

   // R1 / R9: the controller never pushes into a full queue
   a_r9_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
      push_i |-> !full_o);
   // R8: only an occupied head slot retires
   a_r8_pop_occupied: assert property (@(posedge clk) disable iff (!rst_n)
      pop_i |-> (!empty_o && vld_q[rd_ptr]));
endmodule

// File: rtl/wb_issue_pace.sv
module wb_issue_pace #(
   parameter int GAP   = 3,
   localparam int CW   = (GAP > 1) ? $clog2(GAP) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire_i,
   output logic ok_o
);
   if (GAP < 1) $error("wb_issue_pace: GAP must be at least 1");

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)             cnt <= '0;
      else if (fire_i)        cnt <= CW'(GAP - 1);
      else if (cnt != '0)     cnt <= cnt - 1'b1;
   end

   assign ok_o = (cnt == '0);

   // R4: a write is started only when the spacing window has closed
   a_r4_fire_when_ok: assert property (@(posedge clk) disable iff (!rst_n)
      fire_i |-> ok_o);
endmodule

// File: rtl/rd_bypass_wbuf.sv
module rd_bypass_wbuf
   import wb_pkg::*;
#(
   parameter int AW        = 32,
   parameter int DW        = 32,
   parameter int DEPTH     = 6,
   parameter int BLK_WORDS = 8,
   parameter int WR_GAP    = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cpu_wr_req,
   input  logic [AW-1:0] cpu_wr_addr,
   input  logic [DW-1:0] cpu_wr_data,
   output logic          cpu_wr_stall,
   input  logic          cpu_rd_req,
   input  logic [AW-1:0] cpu_rd_addr,
   output logic          cpu_rd_done,
   output logic [DW-1:0] cpu_rd_data,
   input  logic          flush_req,
   output logic          flush_ack,
   output logic          bus_valid,
   output logic          bus_we,
   output logic [AW-1:0] bus_addr,
   output logic [DW-1:0] bus_wdata,
   input  logic          bus_done,
   input  logic          bus_conflict,
   input  logic [DW-1:0] bus_rdata
);
   localparam int BLK_LSB = wb_blk_lsb(BLK_WORDS, DW);
   localparam int IW      = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int GW      = $clog2(WR_GAP + 1) + 1;

   if (DW % 8 != 0) $error("rd_bypass_wbuf: DW must be whole bytes");
   if ((BLK_WORDS & (BLK_WORDS - 1)) != 0) $error("rd_bypass_wbuf: BLK_WORDS must be a power of two");
   if (WR_GAP < 1) $error("rd_bypass_wbuf: WR_GAP must be at least 1");

   wb_state_e        state;
   logic             cur_rd;
   logic             rd_wait, rd_hit_f;
   logic [DEPTH-1:0] rd_mask, hit_vec;
   logic             full, empty, pace_ok;
   logic [IW-1:0]    head_idx;
   logic [AW-1:0]    head_addr;
   logic [DW-1:0]    head_data;
   logic             rd_elig, wr_elig, issue_rd, issue_wr, issue;
   logic             finish, fin_ok, push, pop;

   assign push    = cpu_wr_req && !full;
   assign rd_elig = cpu_rd_req && !cpu_rd_done && (!rd_wait || (rd_mask == '0));
   assign wr_elig = !empty && pace_ok;
   assign issue_rd = (state == WB_IDLE) && rd_elig;
   assign issue_wr = (state == WB_IDLE) && !rd_elig && wr_elig;
   assign issue    = issue_rd || issue_wr;
   assign finish   = (state == WB_BUSY) && bus_done;
   assign fin_ok   = finish && !bus_conflict;
   assign pop      = fin_ok && !cur_rd;

   wb_store_fifo #(
      .DEPTH(DEPTH), .AW(AW), .DW(DW), .BLK_LSB(BLK_LSB)
   ) u_fifo (
      .clk(clk), .rst_n(rst_n),
      .push_i(push), .push_addr_i(cpu_wr_addr), .push_data_i(cpu_wr_data),
      .pop_i(pop), .full_o(full), .empty_o(empty),
      .head_idx_o(head_idx), .head_addr_o(head_addr), .head_data_o(head_data),
      .look_blk_i(cpu_rd_addr[AW-1:BLK_LSB]), .hit_o(hit_vec)
   );

   wb_issue_pace #(.GAP(WR_GAP)) u_pace (
      .clk(clk), .rst_n(rst_n), .fire_i(issue_wr), .ok_o(pace_ok)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state       <= WB_IDLE;
         cur_rd      <= 1'b0;
         bus_valid   <= 1'b0;
         bus_we      <= 1'b0;
         bus_addr    <= '0;
         bus_wdata   <= '0;
         rd_wait     <= 1'b0;
         rd_hit_f    <= 1'b0;
         rd_mask     <= '0;
         cpu_rd_done <= 1'b0;
         cpu_rd_data <= '0;
      end else begin
         cpu_rd_done <= 1'b0;
         if (issue) begin
            state     <= WB_BUSY;
            bus_valid <= 1'b1;
            cur_rd    <= issue_rd;
            bus_we    <= issue_wr;
            bus_addr  <= issue_rd ? cpu_rd_addr : head_addr;
            bus_wdata <= issue_rd ? '0 : head_data;
            if (issue_rd && !rd_wait) begin
               rd_mask  <= hit_vec;
               rd_hit_f <= |hit_vec;
            end
         end else if (finish) begin
            state     <= WB_IDLE;
            bus_valid <= 1'b0;
         end
         if (pop) rd_mask[head_idx] <= 1'b0;
         if (fin_ok && cur_rd) begin
            if (rd_hit_f && !rd_wait) begin
               rd_wait <= 1'b1;
            end else begin
               cpu_rd_done <= 1'b1;
               cpu_rd_data <= bus_rdata;
               rd_wait     <= 1'b0;
               rd_hit_f    <= 1'b0;
            end
         end
      end
   end

   assign cpu_wr_stall = full;
   assign flush_ack    = flush_req && empty;

   // Checker-only state: write-start spacing
   logic          bv_q;
   logic [GW-1:0] gap_cnt;
   logic          wr_start;
   assign wr_start = bus_valid && bus_we && !bv_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bv_q    <= 1'b0;
         gap_cnt <= GW'(WR_GAP);
      end else begin
         bv_q <= bus_valid;
         if (wr_start)                  gap_cnt <= GW'(1);
         else if (gap_cnt < GW'(WR_GAP)) gap_cnt <= gap_cnt + 1'b1;
      end
   end

   // R4: write starts are at least WR_GAP cycles apart
   a_r4_write_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      wr_start |-> (gap_cnt >= GW'(WR_GAP)));
   // R5: a cycle holds steady until the target ends it
   a_r5_hold_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_done) |=> (bus_valid && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));
   // R2: an eligible read wins the next bus cycle
   a_r2_read_first: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == WB_IDLE) && rd_elig) |=> (bus_valid && !bus_we));
   // R3: the retry read waits for the matched stores
   a_r3_retry_waits: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == WB_IDLE) && rd_wait && (rd_mask != '0)) |=> !(bus_valid && !bus_we));
   // R7: no write on the bus while the flush is acknowledged
   a_r7_flush_idle: assert property (@(posedge clk) disable iff (!rst_n)
      flush_ack |-> !(bus_valid && bus_we));
endmodule

// File: tb/rd_bypass_wbuf_test.sv
module rd_bypass_wbuf_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_wr_req = 1'b0;
   logic [31:0] cpu_wr_addr = '0, cpu_wr_data = '0;
   logic        cpu_wr_stall;
   logic        cpu_rd_req = 1'b0;
   logic [31:0] cpu_rd_addr = '0;
   logic        cpu_rd_done;
   logic [31:0] cpu_rd_data;
   logic        flush_req = 1'b0;
   logic        flush_ack;
   logic        bus_valid, bus_we;
   logic [31:0] bus_addr, bus_wdata;
   logic        bus_done = 1'b0, bus_conflict = 1'b0;
   logic [31:0] bus_rdata = '0;

   always #2.5 clk = ~clk;

   rd_bypass_wbuf uut (
      .clk(clk), .rst_n(rst_n),
      .cpu_wr_req(cpu_wr_req), .cpu_wr_addr(cpu_wr_addr), .cpu_wr_data(cpu_wr_data),
      .cpu_wr_stall(cpu_wr_stall),
      .cpu_rd_req(cpu_rd_req), .cpu_rd_addr(cpu_rd_addr), .cpu_rd_done(cpu_rd_done),
      .cpu_rd_data(cpu_rd_data),
      .flush_req(flush_req), .flush_ack(flush_ack),
      .bus_valid(bus_valid), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_done(bus_done), .bus_conflict(bus_conflict), .bus_rdata(bus_rdata)
   );

   int total = 0, bad = 0;
   logic [31:0] ref_mem [logic [31:0]];
   logic [31:0] tmem [logic [31:0]];
   logic [63:0] exp_wr [$];
   logic [63:0] wr_log [$];
   logic        starts [$];
   int  rd_ok = 0, conf_cnt = 0, min_gap = 1000, last_wr = -1000, cyc = 0;
   int  tcnt = 0, tlat = 1, conf_pct = 0;
   logic tgt_hold = 1'b0, force_conf_wr = 1'b0, bv_prev = 1'b0;

   function automatic logic [31:0] init_val(input logic [31:0] a);
      return a ^ 32'h5A5A_1234;
   endfunction

   function automatic logic [31:0] exp_load(input logic [31:0] a);
      return ref_mem.exists(a) ? ref_mem[a] : init_val(a);
   endfunction

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   // bus target model and bus monitor
   initial begin
      forever begin
         @(negedge clk);
         cyc++;
         if (bus_valid && !bv_prev) begin
            starts.push_back(bus_we);
            if (bus_we) begin
               if (cyc - last_wr < min_gap) min_gap = cyc - last_wr;
               last_wr = cyc;
            end
         end
         bv_prev = bus_valid;
         if (bus_done) begin
            bus_done = 1'b0;
            bus_conflict = 1'b0;
         end else if (bus_valid && !tgt_hold) begin
            tcnt++;
            if (tcnt >= tlat) begin
               logic conf;
               if (force_conf_wr && bus_we) begin
                  conf = 1'b1;
                  force_conf_wr = 1'b0;
               end else begin
                  conf = (int'($urandom % 100) < conf_pct);
               end
               if (conf) conf_cnt++;
               else if (bus_we) begin
                  tmem[bus_addr] = bus_wdata;
                  wr_log.push_back({bus_addr, bus_wdata});
               end else begin
                  rd_ok++;
               end
               bus_rdata = tmem.exists(bus_addr) ? tmem[bus_addr] : init_val(bus_addr);
               bus_conflict = conf;
               bus_done = 1'b1;
               tcnt = 0;
               tlat = 1 + int'($urandom % 3);
            end
         end
      end
   end

   task automatic do_store(input logic [31:0] a, input logic [31:0] d, output int stalls);
      stalls = 0;
      @(negedge clk);
      cpu_wr_req = 1'b1; cpu_wr_addr = a; cpu_wr_data = d;
      while (cpu_wr_stall) begin
         stalls++;
         @(negedge clk);
      end
      @(negedge clk);
      cpu_wr_req = 1'b0;
      ref_mem[a] = d;
      exp_wr.push_back({a, d});
   endtask

   task automatic do_load(input logic [31:0] a, output logic [31:0] d);
      @(negedge clk);
      cpu_rd_req = 1'b1; cpu_rd_addr = a;
      do @(negedge clk); while (!cpu_rd_done);
      d = cpu_rd_data;
      cpu_rd_req = 1'b0;
   endtask

   task automatic wait_empty();
      @(negedge clk);
      flush_req = 1'b1;
      #1;
      while (!flush_ack) @(negedge clk);
      flush_req = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic check_order(input string req);
      check(wr_log.size() == exp_wr.size(), req, wr_log.size(), exp_wr.size());
      for (int i = 0; i < exp_wr.size() && i < wr_log.size(); i++)
         if (wr_log[i] != exp_wr[i]) check(1'b0, req, wr_log[i], exp_wr[i]);
      wr_log.delete();
      exp_wr.delete();
   endtask

   // held store(s) ahead, then a load; release the target after a few cycles
   task automatic load_case(input logic [31:0] a, input int exp_reads, input string req);
      int r0;
      logic [31:0] d;
      r0 = rd_ok;
      fork
         do_load(a, d);
         begin repeat (3) @(negedge clk); tgt_hold = 1'b0; end
      join
      check(rd_ok - r0 == exp_reads, req, rd_ok - r0, exp_reads);
      check(d == exp_load(a), req, d, exp_load(a));
      wait_empty();
   endtask

   initial begin
      #(5.0 * 100000);
      total++; bad++;
      $display("FAIL watchdog expired act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int st;
      logic [31:0] d;
      process::self().srandom(32'd7);
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      check(cpu_wr_stall == 1'b0, "R1 reset stall", cpu_wr_stall, 0);
      check(bus_valid == 1'b0, "R5 reset bus idle", bus_valid, 0);
      check(cpu_rd_done == 1'b0, "R3 reset done", cpu_rd_done, 0);
      flush_req = 1'b1; #1;
      check(flush_ack == 1'b1, "R7 empty flush", flush_ack, 1);
      flush_req = 1'b0;

      // R1 / R9 / R7: fill six, then stall
      tgt_hold = 1'b1;
      for (int i = 0; i < 6; i++) begin
         do_store(32'h1000 + 32'(i * 4), 32'hA000 + 32'(i), st);
         check(st == 0, "R1 no stall below six", st, 0);
      end
      @(negedge clk);
      check(cpu_wr_stall == 1'b1, "R9 stall when full", cpu_wr_stall, 1);
      flush_req = 1'b1; #1;
      check(flush_ack == 1'b0, "R7 no ack while queued", flush_ack, 0);
      flush_req = 1'b0;
      fork
         do_store(32'h1018, 32'hA006, st);
         begin
            repeat (4) @(negedge clk);
            check(cpu_wr_stall == 1'b1, "R9 still stalled", cpu_wr_stall, 1);
            tgt_hold = 1'b0;
         end
      join
      check(st >= 4, "R9 store held off", st, 4);
      wait_empty();
      check(1'b1, "R7 ack after drain", 1, 1);
      check_order("R8 fill order");

      // R2: read overtakes queued stores in other blocks
      tgt_hold = 1'b1;
      starts.delete();
      for (int i = 0; i < 3; i++) do_store(32'h2000 + 32'(i * 4), 32'hB000 + 32'(i), st);
      load_case(32'h3000, 1, "R2 R3 no-hit single read");
      check(starts.size() == 4, "R2 start count", starts.size(), 4);
      if (starts.size() == 4)
         check(starts[1] == 1'b0 && starts[2] == 1'b1, "R2 read before queued writes",
               {starts[1], starts[2]}, 2'b01);
      check_order("R8 order after bypass");

      // R3 / R10: same block, different word -> two reads
      tgt_hold = 1'b1;
      do_store(32'h5008, 32'hC001, st);
      do_store(32'h4000, 32'hC002, st);
      load_case(32'h401C, 2, "R10 R3 same block double read");
      // R10: neighbouring block -> one read
      tgt_hold = 1'b1;
      do_store(32'h5010, 32'hC003, st);
      do_store(32'h6000, 32'hC004, st);
      load_case(32'h6020, 1, "R10 next block single read");
      // R3: load after same-address store returns the stored value
      tgt_hold = 1'b1;
      do_store(32'h5018, 32'hC005, st);
      do_store(32'h4000, 32'hC0DE, st);
      load_case(32'h4000, 2, "R3 retry returns new data");
      check_order("R8 order with retries");

      // R5 / R6: conflicted store, load slips in, store reissued
      tgt_hold = 1'b1;
      force_conf_wr = 1'b1;
      starts.delete();
      begin
         int c0;
         c0 = conf_cnt;
         do_store(32'h7000, 32'hD00D, st);
         while (!bus_valid) @(negedge clk);
         fork
            do_load(32'h8000, d);
            begin repeat (2) @(negedge clk); tgt_hold = 1'b0; end
         join
         wait_empty();
         check(conf_cnt - c0 == 1, "R5 one conflict seen", conf_cnt - c0, 1);
         check(d == exp_load(32'h8000), "R6 load data", d, exp_load(32'h8000));
         check(starts.size() == 3, "R6 start count", starts.size(), 3);
         if (starts.size() == 3)
            check({starts[0], starts[1], starts[2]} == 3'b101, "R6 read between attempts",
                  {starts[0], starts[1], starts[2]}, 3'b101);
         check_order("R5 conflicted store retired once");
      end

      // random mix with conflicts
      conf_pct = 20;
      begin
         int c0, lbad;
         c0 = conf_cnt;
         lbad = 0;
         for (int n = 0; n < 400; n++) begin
            logic [31:0] a;
            a = 32'h9000 + 32'(($urandom % 64) * 4);
            if ($urandom % 10 < 6) begin
               do_store(a, $urandom, st);
            end else begin
               do_load(a, d);
               if (d != exp_load(a)) begin
                  lbad++;
                  check(1'b0, "R3 random load data", d, exp_load(a));
               end
            end
         end
         check(lbad == 0, "R3 random loads", lbad, 0);
         wait_empty();
         check(conf_cnt > c0, "R5 random conflicts retried", conf_cnt - c0, 1);
         check_order("R8 random order");
      end
      check(min_gap >= 3, "R4 write start spacing", min_gap, 3);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule